// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address into a linear address for a processor core. A request names an access kind and a 32-bit offset, and may name a segment register explicitly. The unit picks the segment register that applies: the code segment for instruction fetch, the stack segment for push and pop, and the data or extra segment for operand moves. An explicit override on the request replaces that choice. The unit then translates in one of two modes, selected by a mode input.

In real mode the 16-bit segment value is shifted up by four bits and added to the low 16 bits of the offset. The sum is truncated to 20 bits, so addresses wrap at 1 MiB, and different segment:offset pairs can reach the same byte. In protected mode the segment value is a selector whose bits above bit 2 index an eight-entry on-chip descriptor table. The descriptor supplies a base, a size, a privilege level and two type flags. The result is base plus offset, unless a protection check fails, in which case a fault is returned with a zero address.

Software loads the number of usable table entries through a privileged load that only privilege level 0 may perform. Writing the stack segment register also blocks interrupt acceptance until the following instruction has retired. This lets the next instruction set the stack pointer with no interrupt in between. Each request is translated combinationally and the result is registered, with a valid/ready handshake on both sides.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, rsp_valid, irq_inhibit and tbl_ld_fault are 0, req_ready is 1, all four segment registers read 0 and the usable table count is 0.
- R2: In real mode (mode_prot=0) rsp_addr = ((segment << 4) + req_off[15:0]) mod 2^20, with bits 31:20 zero and rsp_fault 0. req_off[31:16] has no effect, and two pairs with equal segment*16+offset give the same address.
- R3: With no override, req_kind 0 (fetch) uses segment register 0 (code), 1 (stack) uses register 1 (stack), 2 (data) uses register 2 (data) and 3 (extra data) uses register 3 (extra). sreg_sel writes the register of the same number.
- R4: With req_ovr_en=1, the segment register numbered by req_ovr_seg (same numbering as R3) is used instead of the default.
- R5: In protected mode the table index is selector bits [5:3] (bits 2:0 are ignored), and a passing access returns rsp_addr = base + req_off with rsp_fault 0.
- R6: In protected mode, an index not below the loaded table count, or an offset not below the descriptor size, gives rsp_fault=1 and rsp_addr=0.
- R7: A table count load (tbl_ld) takes effect only when cpl is 0. Otherwise the count is unchanged and tbl_ld_fault is high for exactly the cycle after the load.
- R8: A request accepted at a clock edge (req_valid and req_ready high) shows its result on rsp_valid/rsp_addr/rsp_fault from that edge on.
- R9: req_ready is 0 while a response is held with rsp_ready low, and the held response stays stable until it is taken.
- R10: A write to segment register 1 raises irq_inhibit from the next cycle. It stays high until the first cycle with instr_done high after the write, and is low the cycle after that. Writes to other segment registers do not raise it.
- R11: In protected mode the access also faults (rsp_addr=0) if the descriptor is not present, if cpl is greater than the descriptor privilege level, or if a fetch (req_kind 0) targets a descriptor without the executable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_prot | input | 1 | 0 = real mode, 1 = protected mode |
| cpl | input | 2 | Current privilege level (0 most privileged) |
| sreg_we | input | 1 | Segment register write enable |
| sreg_sel | input | 2 | Segment register number: 0 code, 1 stack, 2 data, 3 extra |
| sreg_wdata | input | 16 | Value written to the segment register |
| desc_we | input | 1 | Descriptor table write enable |
| desc_idx | input | 3 | Descriptor entry written |
| desc_base | input | 32 | Descriptor base |
| desc_size | input | 32 | Descriptor size in bytes (offsets must be below it) |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present flag |
| desc_exec | input | 1 | Descriptor executable flag |
| tbl_ld | input | 1 | Load the usable table entry count |
| tbl_cnt | input | 4 | Count of usable entries (0 to 8) |
| tbl_ld_fault | output | 1 | One-cycle pulse after a rejected count load |
| instr_done | input | 1 | An instruction retired this cycle |
| irq_inhibit | output | 1 | Interrupt acceptance blocked |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 extra data |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_seg | input | 2 | Override segment register number |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 1 | Protection fault |

## Verification
The bench goes after the 20-bit wrap at segment FFFF and the aliasing of two real-mode pairs. An adder that kept bit 20, or that used the upper offset half, would return a different address. In protected mode it tests offsets one below and exactly at the descriptor size, and selectors at and past the loaded count. An off-by-one compare would pass or fault the wrong one. It tries a count load at a non-zero privilege level and then translates through the table. A design that let the load through would stop faulting on the empty table. It also holds a response under back-pressure and checks the interrupt shadow across an unrelated segment write. An unguarded output register would lose or overwrite the result, and a loose decode would raise the shadow on the wrong register.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 32;
    localparam int LIN_W  = 32;
    localparam int REAL_W = 20;
    localparam int SHIFT  = 4;
    localparam int NSEG   = 4;
    localparam int SEG_IW = $clog2(NSEG);

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_EXTRA = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic present;
        logic exec;
    } seg_type_t;

    typedef struct packed {
        logic [LIN_W-1:0] base;
        logic [OFF_W-1:0] size;
        logic [1:0]       dpl;
        seg_type_t        stype;
    } seg_desc_t;

    typedef struct packed {
        logic             fault;
        logic [LIN_W-1:0] addr;
    } xlate_res_t;

    // Implicit segment for each access kind.
    function automatic seg_id_e default_seg(input acc_kind_e k);
        seg_id_e s;
        unique case (k)
            ACC_FETCH: s = SEG_CODE;
            ACC_STACK: s = SEG_STACK;
            ACC_DATA:  s = SEG_DATA;
            ACC_EXTRA: s = SEG_EXTRA;
            default:   s = SEG_DATA;
        endcase
        return s;
    endfunction

    // Shift-and-add real-mode address; carry out of the top bit is dropped.
    function automatic logic [REAL_W-1:0] real_linear(input logic [SEL_W-1:0] seg,
                                                      input logic [SEL_W-1:0] off);
        logic [REAL_W-1:0] s;
        logic [REAL_W-1:0] o;
        s = {seg, {SHIFT{1'b0}}};
        o = {{(REAL_W-SEL_W){1'b0}}, off};
        return s + o;
    endfunction

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_xlate_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int W  = SEL_W,
    parameter int SW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SW-1:0]       wsel,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] regs
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        localparam logic [SW-1:0] MY_ID = SW'(g);
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wsel == MY_ID))
                regs[g] <= wdata;
        end
    end

endmodule

// File: rtl/desc_table.sv
module desc_table
    import seg_xlate_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  seg_desc_t     wr_desc,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_cnt,
    input  logic [1:0]    cpl,
    input  logic [IW-1:0] rd_idx,
    output seg_desc_t     rd_desc,
    output logic [CW-1:0] count,
    output logic          ld_fault
);

    seg_desc_t ents [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [IW-1:0] MY_IDX = IW'(g);
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (wr_en && (wr_idx == MY_IDX))
                ents[g] <= wr_desc;
        end
    end

    assign rd_desc = ents[rd_idx];

    logic ld_ok;
    assign ld_ok = ld_en && (cpl == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            ld_fault <= 1'b0;
        end else begin
            if (ld_ok)
                count <= ld_cnt;
            ld_fault <= ld_en && !ld_ok;
        end
    end

endmodule

// File: rtl/xlate_core.sv
module xlate_core
    import seg_xlate_pkg::*;
#(
    parameter int IW = 3,
    parameter int CW = IW + 1
) (
    input  logic                      mode_prot,
    input  logic [1:0]                cpl,
    input  logic [1:0]                kind,
    input  logic                      ovr_en,
    input  logic [1:0]                ovr_seg,
    input  logic [OFF_W-1:0]          off,
    input  logic [NSEG-1:0][SEL_W-1:0] segs,
    input  seg_desc_t                 desc,
    input  logic [CW-1:0]             count,
    output logic [IW-1:0]             tbl_idx,
    output xlate_res_t                res
);

    acc_kind_e        akind;
    seg_id_e          sid;
    logic [SEL_W-1:0] sel;

    assign akind   = acc_kind_e'(kind);
    assign sid     = ovr_en ? seg_id_e'(ovr_seg) : default_seg(akind);
    assign sel     = segs[sid];
    assign tbl_idx = sel[IW+2:3];

    logic idx_bad, lim_bad, abs_bad, priv_bad, exec_bad, prot_fault;

    always_comb begin
        idx_bad    = ({1'b0, tbl_idx} >= count);
        lim_bad    = (off >= desc.size);
        abs_bad    = !desc.stype.present;
        priv_bad   = (cpl > desc.dpl);
        exec_bad   = (akind == ACC_FETCH) && !desc.stype.exec;
        prot_fault = idx_bad || lim_bad || abs_bad || priv_bad || exec_bad;
    end

    always_comb begin
        if (!mode_prot) begin
            res.fault = 1'b0;
            res.addr  = {{(LIN_W-REAL_W){1'b0}}, real_linear(sel, off[SEL_W-1:0])};
        end else if (prot_fault) begin
            res.fault = 1'b1;
            res.addr  = '0;
        end else begin
            res.fault = 1'b0;
            res.addr  = desc.base + off;
        end
    end

endmodule

// File: rtl/irq_shadow.sv
module irq_shadow (
    input  logic clk,
    input  logic rst,
    input  logic ss_write,
    input  logic instr_done,
    output logic inhibit
);

    always_ff @(posedge clk) begin
        if (rst)
            inhibit <= 1'b0;
        else if (ss_write)
            inhibit <= 1'b1;
        else if (instr_done)
            inhibit <= 1'b0;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int DESC_N = 8,
    parameter int IDX_W  = $clog2(DESC_N),
    parameter int CNT_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_prot,
    input  logic [1:0]       cpl,
    input  logic             sreg_we,
    input  logic [1:0]       sreg_sel,
    input  logic [15:0]      sreg_wdata,
    input  logic             desc_we,
    input  logic [IDX_W-1:0] desc_idx,
    input  logic [31:0]      desc_base,
    input  logic [31:0]      desc_size,
    input  logic [1:0]       desc_dpl,
    input  logic             desc_present,
    input  logic             desc_exec,
    input  logic             tbl_ld,
    input  logic [CNT_W-1:0] tbl_cnt,
    output logic             tbl_ld_fault,
    input  logic             instr_done,
    output logic             irq_inhibit,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic             req_ovr_en,
    input  logic [1:0]       req_ovr_seg,
    input  logic [31:0]      req_off,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [31:0]      rsp_addr,
    output logic             rsp_fault
);

    logic [NSEG-1:0][SEL_W-1:0] segs;
    seg_desc_t                  wr_desc, rd_desc;
    logic [IDX_W-1:0]           rd_idx;
    logic [CNT_W-1:0]           count;
    xlate_res_t                 res, rsp_q;
    logic                       accept, ss_write;

    seg_regfile #(.N(NSEG), .W(SEL_W)) u_sregs (
        .clk   (clk),
        .rst   (rst),
        .we    (sreg_we),
        .wsel  (sreg_sel),
        .wdata (sreg_wdata),
        .regs  (segs)
    );

    always_comb begin
        wr_desc.base          = desc_base;
        wr_desc.size          = desc_size;
        wr_desc.dpl           = desc_dpl;
        wr_desc.stype.present = desc_present;
        wr_desc.stype.exec    = desc_exec;
    end

    desc_table #(.DEPTH(DESC_N)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (desc_we),
        .wr_idx   (desc_idx),
        .wr_desc  (wr_desc),
        .ld_en    (tbl_ld),
        .ld_cnt   (tbl_cnt),
        .cpl      (cpl),
        .rd_idx   (rd_idx),
        .rd_desc  (rd_desc),
        .count    (count),
        .ld_fault (tbl_ld_fault)
    );

    xlate_core #(.IW(IDX_W)) u_core (
        .mode_prot (mode_prot),
        .cpl       (cpl),
        .kind      (req_kind),
        .ovr_en    (req_ovr_en),
        .ovr_seg   (req_ovr_seg),
        .off       (req_off),
        .segs      (segs),
        .desc      (rd_desc),
        .count     (count),
        .tbl_idx   (rd_idx),
        .res       (res)
    );

    assign ss_write = sreg_we && (sreg_sel == SEG_STACK);

    irq_shadow u_shadow (
        .clk        (clk),
        .rst        (rst),
        .ss_write   (ss_write),
        .instr_done (instr_done),
        .inhibit    (irq_inhibit)
    );

    // Output stage: one result register with back-pressure.
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_q     <= res;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    assign rsp_addr  = rsp_q.addr;
    assign rsp_fault = rsp_q.fault;

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker (
    input logic        clk,
    input logic        rst,
    input logic        mode_prot,
    input logic [1:0]  cpl,
    input logic        sreg_we,
    input logic [1:0]  sreg_sel,
    input logic        tbl_ld,
    input logic        tbl_ld_fault,
    input logic        instr_done,
    input logic        irq_inhibit,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_addr,
    input logic        rsp_fault
);

    logic real_seen;
    always_ff @(posedge clk) begin
        if (rst)
            real_seen <= 1'b0;
        else if (req_valid && req_ready)
            real_seen <= !mode_prot;
    end

    AST_REAL_20BIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && real_seen) |-> (rsp_addr[31:20] == 12'h000 && !rsp_fault)); // R2

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == 32'h0)); // R6

    AST_TBL_REJECT: assert property (@(posedge clk) disable iff (rst)
        (tbl_ld && cpl != 2'd0) |=> tbl_ld_fault); // R7

    AST_TBL_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (tbl_ld && cpl == 2'd0) |=> !tbl_ld_fault); // R7

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault))); // R9

    AST_SHADOW_SET: assert property (@(posedge clk) disable iff (rst)
        (sreg_we && sreg_sel == 2'd1) |=> irq_inhibit); // R10

    AST_SHADOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (instr_done && !(sreg_we && sreg_sel == 2'd1)) |=> !irq_inhibit); // R10

endmodule

bind seg_xlate_unit seg_xlate_checker u_chk (.*);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_prot = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic        sreg_we = 1'b0;
    logic [1:0]  sreg_sel = 2'd0;
    logic [15:0] sreg_wdata = 16'h0;
    logic        desc_we = 1'b0;
    logic [2:0]  desc_idx = 3'd0;
    logic [31:0] desc_base = 32'h0;
    logic [31:0] desc_size = 32'h0;
    logic [1:0]  desc_dpl = 2'd0;
    logic        desc_present = 1'b0;
    logic        desc_exec = 1'b0;
    logic        tbl_ld = 1'b0;
    logic [3:0]  tbl_cnt = 4'd0;
    logic        tbl_ld_fault;
    logic        instr_done = 1'b0;
    logic        irq_inhibit;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic        req_ovr_en = 1'b0;
    logic [1:0]  req_ovr_seg = 2'd0;
    logic [31:0] req_off = 32'h0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_addr;
    logic        rsp_fault;

    always #5 clk = ~clk;

    seg_xlate_unit dut (.*);

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_addr_q [$];
    logic        exp_fault_q [$];
    string       tag_q [$];

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rexp(input logic [15:0] seg, input logic [31:0] off);
        logic [31:0] s;
        s = ({16'h0, seg} * 32'd16) + {16'h0, off[15:0]};
        return s & 32'h000F_FFFF;
    endfunction

    // Monitor: pops the scoreboard when a response is taken.
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R8 response with nothing outstanding", rsp_addr, 32'h0);
            end else begin
                logic [31:0] ea;
                logic        ef;
                string       t;
                ea = exp_addr_q.pop_front();
                ef = exp_fault_q.pop_front();
                t  = tag_q.pop_front();
                check(rsp_addr == ea, {t, " addr"}, rsp_addr, ea);
                check(rsp_fault == ef, {t, " fault"}, {31'h0, rsp_fault}, {31'h0, ef});
            end
        end
    end

    task automatic issue(input logic prot, input logic [1:0] kind, input logic oe,
                         input logic [1:0] os, input logic [31:0] off,
                         input logic [31:0] ea, input logic ef, input string tag);
        @(posedge clk); #1;
        mode_prot = prot; req_kind = kind; req_ovr_en = oe; req_ovr_seg = os;
        req_off = off; req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_addr_q.push_back(ea);
        exp_fault_q.push_back(ef);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R8 result one cycle after accept", {31'h0, rsp_valid}, 32'h1);
    endtask

    task automatic write_seg(input logic [1:0] id, input logic [15:0] v);
        @(posedge clk); #1;
        sreg_we = 1'b1; sreg_sel = id; sreg_wdata = v;
        @(posedge clk); #1;
        sreg_we = 1'b0;
    endtask

    task automatic write_desc(input logic [2:0] i, input logic [31:0] b, input logic [31:0] s,
                              input logic [1:0] d, input logic p, input logic x);
        @(posedge clk); #1;
        desc_we = 1'b1; desc_idx = i; desc_base = b; desc_size = s;
        desc_dpl = d; desc_present = p; desc_exec = x;
        @(posedge clk); #1;
        desc_we = 1'b0;
    endtask

    task automatic load_tbl(input logic [1:0] lvl, input logic [3:0] n, input logic exp_f);
        @(posedge clk); #1;
        cpl = lvl; tbl_ld = 1'b1; tbl_cnt = n;
        @(posedge clk); #1;
        tbl_ld = 1'b0;
        check(tbl_ld_fault == exp_f, "R7 load fault flag", {31'h0, tbl_ld_fault}, {31'h0, exp_f});
        @(posedge clk); #1;
        check(tbl_ld_fault == 1'b0, "R7 fault flag lasts one cycle", {31'h0, tbl_ld_fault}, 32'h0);
    endtask

    task automatic pulse_done();
        @(posedge clk); #1;
        instr_done = 1'b1;
        @(posedge clk); #1;
        instr_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        check(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
        check(irq_inhibit == 1'b0, "R1 irq_inhibit after reset", {31'h0, irq_inhibit}, 32'h0);
        check(tbl_ld_fault == 1'b0, "R1 tbl_ld_fault after reset", {31'h0, tbl_ld_fault}, 32'h0);
        issue(1'b0, 2'd2, 1'b0, 2'd0, 32'h0000_1234, 32'h0000_1234, 1'b0, "R1 segment regs reset to 0");
        issue(1'b1, 2'd0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b1, "R1 empty table count faults");

        // Real mode
        write_seg(2'd0, 16'h1000);
        write_seg(2'd1, 16'h2000);
        write_seg(2'd2, 16'hA5C0);
        write_seg(2'd3, 16'hFFFF);
        issue(1'b0, 2'd0, 1'b0, 2'd0, 32'h0123, rexp(16'h1000, 32'h0123), 1'b0, "R3 fetch uses code");
        issue(1'b0, 2'd1, 1'b0, 2'd0, 32'hFFFE, rexp(16'h2000, 32'hFFFE), 1'b0, "R3 stack uses stack");
        issue(1'b0, 2'd2, 1'b0, 2'd0, 32'h2DE1, 32'h000A_89E1, 1'b0, "R3 data uses data");
        issue(1'b0, 2'd3, 1'b0, 2'd0, 32'h0010, 32'h0000_0000, 1'b0, "R2 wrap at 1 MiB");
        issue(1'b0, 2'd3, 1'b0, 2'd0, 32'h000F, 32'h000F_FFFF, 1'b0, "R2 top byte");
        issue(1'b0, 2'd2, 1'b0, 2'd0, 32'hDEAD_2DE1, 32'h000A_89E1, 1'b0, "R2 upper offset ignored");
        write_seg(2'd2, 16'hA5BF);
        issue(1'b0, 2'd2, 1'b0, 2'd0, 32'h2DF1, 32'h000A_89E1, 1'b0, "R2 alias pair");
        issue(1'b0, 2'd0, 1'b1, 2'd2, 32'h0001, rexp(16'hA5BF, 32'h0001), 1'b0, "R4 fetch overridden to data");
        issue(1'b0, 2'd2, 1'b1, 2'd1, 32'h0000, 32'h0002_0000, 1'b0, "R4 data overridden to stack");

        // Interrupt shadow
        pulse_done();
        check(irq_inhibit == 1'b0, "R10 cleared by retire", {31'h0, irq_inhibit}, 32'h0);
        write_seg(2'd2, 16'h0010);
        check(irq_inhibit == 1'b0, "R10 data write no shadow", {31'h0, irq_inhibit}, 32'h0);
        write_seg(2'd1, 16'h0028);
        check(irq_inhibit == 1'b1, "R10 stack write sets shadow", {31'h0, irq_inhibit}, 32'h1);
        repeat (2) @(posedge clk);
        #1 check(irq_inhibit == 1'b1, "R10 shadow held until retire", {31'h0, irq_inhibit}, 32'h1);
        pulse_done();
        check(irq_inhibit == 1'b0, "R10 shadow cleared after retire", {31'h0, irq_inhibit}, 32'h0);

        // Protected mode
        write_desc(3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 2'd3, 1'b1, 1'b1);
        write_desc(3'd2, 32'h0010_0000, 32'h0000_1000, 2'd3, 1'b1, 1'b0);
        write_desc(3'd3, 32'h4000_0000, 32'h0000_0100, 2'd0, 1'b1, 1'b0);
        write_desc(3'd4, 32'h0000_0000, 32'h0000_0100, 2'd3, 1'b0, 1'b0);
        write_desc(3'd5, 32'h8000_0000, 32'h0000_0010, 2'd3, 1'b1, 1'b0);
        write_seg(2'd0, 16'h0000);
        write_seg(2'd3, 16'h0018);
        cpl = 2'd3;
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h10, 32'h0, 1'b1, "R6 index not below count 0");
        load_tbl(2'd3, 4'd6, 1'b1);
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h10, 32'h0, 1'b1, "R7 rejected load left count");
        load_tbl(2'd0, 4'd6, 1'b0);
        cpl = 2'd3;
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h0FFF, 32'h0010_0FFF, 1'b0, "R5 last byte in segment");
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h1000, 32'h0, 1'b1, "R6 offset equal to size");
        issue(1'b1, 2'd1, 1'b0, 2'd0, 32'h000F, 32'h8000_000F, 1'b0, "R5 stack descriptor");
        issue(1'b1, 2'd1, 1'b0, 2'd0, 32'h0010, 32'h0, 1'b1, "R6 stack over size");
        issue(1'b1, 2'd0, 1'b0, 2'd0, 32'h1234_5678, 32'h1234_5678, 1'b0, "R5 flat code fetch");
        issue(1'b1, 2'd0, 1'b1, 2'd2, 32'h0, 32'h0, 1'b1, "R11 fetch from non-exec");
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'h10, 32'h0, 1'b1, "R11 cpl above dpl");
        cpl = 2'd0;
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'h10, 32'h4000_0010, 1'b0, "R11 cpl 0 passes");
        write_seg(2'd3, 16'h0020);
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'h10, 32'h0, 1'b1, "R11 not present");
        write_seg(2'd3, 16'h0038);
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'h0, 32'h0, 1'b1, "R6 index 7 beyond count 6");
        write_seg(2'd2, 16'h0017);
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h20, 32'h0010_0020, 1'b0, "R5 selector low bits ignored");

        // Back-pressure
        @(posedge clk); #1 rsp_ready = 1'b0;
        issue(1'b1, 2'd2, 1'b0, 2'd0, 32'h4, 32'h0010_0004, 1'b0, "R9 held response");
        check(req_ready == 1'b0, "R9 not ready while held", {31'h0, req_ready}, 32'h0);
        held = rsp_addr;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_addr == held, "R9 response stable while held", rsp_addr, held);
        @(posedge clk); #1 rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(exp_addr_q.size() == 0, "R8 all responses seen",
              exp_addr_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule